// File: doc/BRIEF.md
# SD Host Receive Path with Tuning Handshake

This block is the receive half of an SD host controller's data path. Card bytes arrive one per cycle on a byte stream and land in a block buffer. Software drains that buffer through a byte data port. A small register bus holds the block size, block count, transfer mode, interrupt status and signal enable. It also holds the second host control register, which carries the execute-tuning and sampling-clock-select bits used for receive tuning.

When software sets execute-tuning before requesting a block, the block is still pulled from the card byte by byte, but nothing is written into the buffer. When the block ends, the hardware finishes the tuning handshake in a single update: execute-tuning drops, sampling-clock-select rises, and the transfer-busy bits of the present state fall. Buffer-read-ready is never raised for such a block. A 32-bit read at the auto-CMD12 error status offset returns that status in its low half and the second host control register in its high half.

Top module: `sd_tune_rx`

## Requirements
- R1: After reset, the second host control register, present state (read at 0x24), interrupt status (read at 0x30) and the irq output are all zero.
- R2: Writes to the second host control register (16-bit write at 0x3E) keep bits 15, 14 and 7:0 as written; bits 13:8 always read as zero.
- R3: A read at 0x3C returns the acmd12_sts input in bits 15:0 and the second host control register in bits 31:16.
- R4: Outside tuning, the bytes of a block are stored from buffer index 0 upward in arrival order, and each buf_pop returns the next one on buf_data, starting at index 0.
- R5: Outside tuning, the edge after the one that takes a block's last byte sets present-state bit 11 (data available) and interrupt status bit 5 (buffer read ready); neither is set before that edge.
- R6: A block requested while execute-tuning (bit 6) is 1 consumes all of its bytes, writes nothing into the buffer and sets neither present-state bit 11 nor status bit 5.
- R7: The edge after a tuning block's last byte clears execute-tuning (bit 6) and sets sampling-clock-select (bit 7) together, and leaves the other bits of the register unchanged.
- R8: That same edge clears present-state bits 1 (data inhibit), 2 (data line active) and 9 (read transfer active). An accepted request sets all three bits.
- R9: A block request is ignored when transfer mode bit 5 (multi-block) and bit 1 (count enable) are both set and the block count (bits 31:16 of a read at 0x04) is zero.
- R10: The byte count of a block is the block size register (16-bit write at 0x04) masked to bits 11:0.
- R11: The irq output is 1 one cycle after any interrupt status bit and its signal-enable bit (16-bit write at 0x38) are both 1. Status bits are cleared by writing 1 at 0x30.
- R12: An accepted request decrements a non-zero block count when count enable is set. It never wraps a zero count.
- R13: The pop that takes the last byte of a stored block clears present-state bits 11, 9, 2 and 1.
- R14: A block request while the block size field is zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the 16-bit register written |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Word-aligned byte offset of the 32-bit read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| acmd12_sts | input | 16 | Auto-CMD12 error status from the command side |
| blk_req | input | 1 | Request to receive one block |
| card_valid | input | 1 | Card byte present this cycle |
| card_byte | input | 8 | Card byte |
| buf_pop | input | 1 | Take one byte from the buffer data port |
| buf_data | output | 8 | Byte at the buffer read position |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with a 16-byte buffer (ADDR_W = 4) and the default 12-bit block size field. With that buffer, every block length from 1 to 16 can be swept through both the stored path and the tuning path, with byte patterns computed arithmetically from the length. Each tuning pass also loads a different arrangement of the untouched register bits. The small buffer further allows a half-drained stored block to sit across a complete tuning block, which shows at the data port that tuning writes nothing.

// File: rtl/sdt_pkg.sv
// Package: shared register offsets, field positions and state type for
// the SD receive/tuning block. Offsets and bit positions are behavioural:
// software and the bench decode them.
package sdt_pkg;
    // register byte offsets
    localparam logic [7:0] OFS_BLK   = 8'h04;
    localparam logic [7:0] OFS_BCNT  = 8'h06;
    localparam logic [7:0] OFS_XMODE = 8'h0C;
    localparam logic [7:0] OFS_PRES  = 8'h24;
    localparam logic [7:0] OFS_STS   = 8'h30;
    localparam logic [7:0] OFS_SIGEN = 8'h38;
    localparam logic [7:0] OFS_AC12  = 8'h3C;
    localparam logic [7:0] OFS_HC2   = 8'h3E;

    // second host control register fields
    localparam int HC2_EXEC_BIT   = 6;
    localparam int HC2_CLKSEL_BIT = 7;
    localparam logic [15:0] HC2_WMASK = 16'hC0FF;

    // transfer mode bits
    localparam int XM_CNTEN = 1;
    localparam int XM_MULTI = 5;

    // present state bits
    localparam int PS_INHIBIT = 1;
    localparam int PS_DATACT  = 2;
    localparam int PS_RDACT   = 9;
    localparam int PS_AVAIL   = 11;

    // interrupt status bits implemented
    localparam int STS_RDY_BIT = 5;
    localparam logic [15:0] STS_IMPL = 16'h0020;

    typedef enum logic {RX_IDLE, RX_BUSY} rx_state_t;
endpackage

// File: rtl/sdt_hc2_reg.sv
// Module: second host control register.
// Holds the 16-bit register with reserved bits forced to zero. A software
// write is applied first; a tuning-complete pulse in the same cycle then
// clears execute-tuning and sets sampling-clock-select on top of it.
// Assumes: wr_hit is a single-cycle strobe already decoded for this offset.
module sdt_hc2_reg
    import sdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [15:0] wr_data,
    input  logic        tune_done,
    output logic [15:0] hc2
);
    logic [15:0] hc2_nxt;

    // next value: write merge, then tuning completion update
    always_comb begin
        hc2_nxt = hc2;
        if (wr_hit) hc2_nxt = wr_data & HC2_WMASK;
        if (tune_done) begin
            hc2_nxt[HC2_EXEC_BIT]   = 1'b0;
            hc2_nxt[HC2_CLKSEL_BIT] = 1'b1;
        end
    end

    // register storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) hc2 <= '0;
        else        hc2 <= hc2_nxt;
    end

    // R7
    tune_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tune_done |=> (hc2[HC2_CLKSEL_BIT] && !hc2[HC2_EXEC_BIT]));

    // R7
    tune_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_done && !wr_hit) |=> (hc2[5:0] == $past(hc2[5:0]) &&
                                    hc2[15:14] == $past(hc2[15:14])));
endmodule

// File: rtl/sdt_block_buf.sv
// Module: block buffer storage.
// One write port, one asynchronous read port, byte wide. Contents are not
// reset; readers only look at indices written by a completed block.
module sdt_block_buf #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // byte write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // byte read at the current read position
    assign rdata = mem[raddr];
endmodule

// File: rtl/sdt_rx_ctrl.sv
// Module: receive sequencer.
// Accepts a block request, counts card bytes up to the latched length and
// either stores them (normal) or drops them (tuning, decided at request
// time). The cycle after the last byte it issues either rdy_set (normal)
// or tune_done (tuning). It also tracks the data-port read position and
// the busy/available flags behind the present state.
// Assumes: blocked is decoded by the owner of the count registers.
module sdt_rx_ctrl
    import sdt_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BLKSZ_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [BLKSZ_W-1:0] blk_size,
    input  logic               blocked,
    input  logic               tune_mode,
    input  logic               card_valid,
    input  logic [7:0]         card_byte,
    input  logic               pop,
    output logic               accept,
    output logic               buf_we,
    output logic [ADDR_W-1:0]  buf_waddr,
    output logic [7:0]         buf_wdata,
    output logic [ADDR_W-1:0]  buf_raddr,
    output logic               tune_done,
    output logic               rdy_set,
    output logic               busy,
    output logic               avail
);
    localparam logic [BLKSZ_W-1:0] ONE = BLKSZ_W'(1);

    rx_state_t          state;
    logic [BLKSZ_W-1:0] cnt, len, rd_idx, rd_len;
    logic               tune_blk, done_q, done_tune_q;

    // request qualification
    assign accept = (state == RX_IDLE) && req && !blocked && (blk_size != '0);

    // buffer write side: only outside tuning
    assign buf_we    = (state == RX_BUSY) && card_valid && !tune_blk;
    assign buf_waddr = cnt[ADDR_W-1:0];
    assign buf_wdata = card_byte;
    assign buf_raddr = rd_idx[ADDR_W-1:0];

    // end-of-block outcome pulses
    assign tune_done = done_q && done_tune_q;
    assign rdy_set   = done_q && !done_tune_q;

    // sequencer, read position and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            cnt         <= '0;
            len         <= '0;
            rd_idx      <= '0;
            rd_len      <= '0;
            tune_blk    <= 1'b0;
            done_q      <= 1'b0;
            done_tune_q <= 1'b0;
            busy        <= 1'b0;
            avail       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            // completion and drain first so a new accept wins on busy
            if (tune_done) busy <= 1'b0;
            if (rdy_set) begin
                avail  <= 1'b1;
                rd_idx <= '0;
                rd_len <= len;
            end else if (avail && pop) begin
                rd_idx <= rd_idx + ONE;
                if (rd_idx == rd_len - ONE) begin
                    avail <= 1'b0;
                    busy  <= 1'b0;
                end
            end
            case (state)
                RX_IDLE: begin
                    if (accept) begin
                        state    <= RX_BUSY;
                        cnt      <= '0;
                        len      <= blk_size;
                        tune_blk <= tune_mode;
                        busy     <= 1'b1;
                    end
                end
                default: begin
                    if (card_valid) begin
                        cnt <= cnt + ONE;
                        if (cnt == len - ONE) begin
                            state       <= RX_IDLE;
                            done_q      <= 1'b1;
                            done_tune_q <= tune_blk;
                        end
                    end
                end
            endcase
        end
    end

    // R5
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail) |-> $past(rdy_set));

    // R6
    tune_no_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_done && !pop) |=> $stable(avail));
endmodule

// File: rtl/sd_tune_rx.sv
// Module: SD host receive path with tuning handshake (top).
// Owns the bus-visible registers (block size, block count, transfer mode,
// interrupt status and enable), the read mux and the registered irq, and
// joins the control register, sequencer and buffer.
// Assumes: 16-bit writes at even offsets, 32-bit reads at word offsets.
module sd_tune_rx
    import sdt_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BLKSZ_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic [15:0] acmd12_sts,
    input  logic        blk_req,
    input  logic        card_valid,
    input  logic [7:0]  card_byte,
    input  logic        buf_pop,
    output logic [7:0]  buf_data,
    output logic        irq
);
    localparam int PAD_W = 16 - BLKSZ_W;

    logic [BLKSZ_W-1:0] blksz_q;
    logic [15:0]        bcnt_q, xmode_q, sts_q, sigen_q, sts_nxt, hc2;
    logic [31:0]        pres_w;
    logic               wr_blk, wr_bcnt, wr_xmode, wr_sts, wr_sigen, wr_hc2;
    logic               blocked, accept, tune_done, rdy_set, busy, avail;
    logic               buf_we;
    logic [ADDR_W-1:0]  buf_waddr, buf_raddr;
    logic [7:0]         buf_wdata;

    // write strobe decode
    assign wr_blk   = wr_en && (wr_addr == OFS_BLK);
    assign wr_bcnt  = wr_en && (wr_addr == OFS_BCNT);
    assign wr_xmode = wr_en && (wr_addr == OFS_XMODE);
    assign wr_sts   = wr_en && (wr_addr == OFS_STS);
    assign wr_sigen = wr_en && (wr_addr == OFS_SIGEN);
    assign wr_hc2   = wr_en && (wr_addr == OFS_HC2);

    // zero-count multi-block guard
    assign blocked = xmode_q[XM_MULTI] && xmode_q[XM_CNTEN] && (bcnt_q == '0);

    // present state assembly
    always_comb begin
        pres_w             = '0;
        pres_w[PS_INHIBIT] = busy;
        pres_w[PS_DATACT]  = busy;
        pres_w[PS_RDACT]   = busy;
        pres_w[PS_AVAIL]   = avail;
    end

    // interrupt status next value: write-1-clear, hardware set wins
    always_comb begin
        sts_nxt = sts_q;
        if (wr_sts) sts_nxt = sts_nxt & ~wr_data;
        if (rdy_set) sts_nxt[STS_RDY_BIT] = 1'b1;
        sts_nxt = sts_nxt & STS_IMPL;
    end

    // software-owned registers, block count and irq
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blksz_q <= '0;
            bcnt_q  <= '0;
            xmode_q <= '0;
            sts_q   <= '0;
            sigen_q <= '0;
            irq     <= 1'b0;
        end else begin
            if (wr_blk)   blksz_q <= wr_data[BLKSZ_W-1:0];
            if (wr_xmode) xmode_q <= wr_data;
            if (wr_sigen) sigen_q <= wr_data;
            if (wr_bcnt) bcnt_q <= wr_data;
            else if (accept && xmode_q[XM_CNTEN] && bcnt_q != '0)
                bcnt_q <= bcnt_q - 16'd1;
            sts_q <= sts_nxt;
            irq   <= |(sts_q & sigen_q);
        end
    end

    // 32-bit read mux
    always_comb begin
        case (rd_addr)
            OFS_BLK:   rd_data = {bcnt_q, {PAD_W{1'b0}}, blksz_q};
            OFS_XMODE: rd_data = {16'h0, xmode_q};
            OFS_PRES:  rd_data = pres_w;
            OFS_STS:   rd_data = {16'h0, sts_q};
            OFS_SIGEN: rd_data = {16'h0, sigen_q};
            OFS_AC12:  rd_data = {hc2, acmd12_sts};
            default:   rd_data = '0;
        endcase
    end

    sdt_hc2_reg u_hc2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hc2),
        .wr_data   (wr_data),
        .tune_done (tune_done),
        .hc2       (hc2)
    );

    sdt_rx_ctrl #(.ADDR_W(ADDR_W), .BLKSZ_W(BLKSZ_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (blk_req),
        .blk_size   (blksz_q),
        .blocked    (blocked),
        .tune_mode  (hc2[HC2_EXEC_BIT]),
        .card_valid (card_valid),
        .card_byte  (card_byte),
        .pop        (buf_pop),
        .accept     (accept),
        .buf_we     (buf_we),
        .buf_waddr  (buf_waddr),
        .buf_wdata  (buf_wdata),
        .buf_raddr  (buf_raddr),
        .tune_done  (tune_done),
        .rdy_set    (rdy_set),
        .busy       (busy),
        .avail      (avail)
    );

    sdt_block_buf #(.ADDR_W(ADDR_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_data)
    );

    // R8
    tune_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_done && !accept) |=>
            (!pres_w[PS_INHIBIT] && !pres_w[PS_DATACT] && !pres_w[PS_RDACT]));

    // R9
    zero_count_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && blocked && !busy) |=> !busy);

    // R12
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xmode_q[XM_CNTEN] && bcnt_q != '0 && !wr_bcnt) |=>
            (bcnt_q == $past(bcnt_q) - 16'd1));
endmodule

// File: tb/tb_sd_tune_rx.sv
module tb_sd_tune_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] acmd12_sts = '0;
    logic        blk_req = 1'b0;
    logic        card_valid = 1'b0;
    logic [7:0]  card_byte = '0;
    logic        buf_pop = 1'b0;
    logic [7:0]  buf_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    sd_tune_rx #(.ADDR_W(4), .BLKSZ_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .acmd12_sts(acmd12_sts), .blk_req(blk_req), .card_valid(card_valid),
        .card_byte(card_byte), .buf_pop(buf_pop), .buf_data(buf_data),
        .irq(irq)
    );

    always #2 clk = ~clk;

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 8'hFF);
    endfunction

    task automatic wr16(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // request then stream n bytes; returns at the negedge after the last byte edge
    task automatic recv(input int n, input int seed);
        @(negedge clk);
        blk_req = 1'b1;
        @(negedge clk);
        blk_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            card_valid = 1'b1;
            card_byte  = pat(seed, i);
            @(negedge clk);
        end
        card_valid = 1'b0;
    endtask

    // pop count bytes starting at index first, comparing against seed pattern
    task automatic drain(input int seed, input int first, input int count, input string req);
        for (int i = first; i < first + count; i++) begin
            chk(req, {24'h0, buf_data}, {24'h0, pat(seed, i)});
            buf_pop = 1'b1;
            @(negedge clk);
            buf_pop = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [15:0] v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd32(8'h3C, d); chk("R1 hc2", d, 32'h0);
        rd32(8'h24, d); chk("R1 pres", d, 32'h0);
        rd32(8'h30, d); chk("R1 sts", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2, R3 register write mask and packed read
        for (int k = 0; k < 8; k++) begin
            v = 16'(16'hFFFF - k * 16'h1357);
            acmd12_sts = 16'(16'h1234 + k * 16'h0101);
            wr16(8'h3E, v);
            rd32(8'h3C, d);
            chk("R2 R3 hc2 pack", d, {v & 16'hC0FF, acmd12_sts});
            chk("R2 reserved", {16'h0, d[31:16] & 16'h3F00}, 32'h0);
        end
        wr16(8'h3E, 16'h0000);
        wr16(8'h38, 16'h0020);

        // R4 R5 R10 R11 R13 normal blocks of every length
        for (int n = 1; n <= 16; n++) begin
            wr16(8'h04, 16'(16'hF000 | n));          // R10 upper bits masked off
            recv(n, n);
            rd32(8'h24, d); chk("R5 not yet avail", d, 32'h0206);
            rd32(8'h30, d); chk("R5 not yet sts", d, 32'h0);
            @(negedge clk);
            rd32(8'h24, d); chk("R5 avail", d, 32'h0A06);
            rd32(8'h30, d); chk("R5 sts", d, 32'h0020);
            @(negedge clk);
            chk("R11 irq", {31'h0, irq}, 32'h1);
            drain(n, 0, n, "R4 data order");
            rd32(8'h24, d); chk("R13 drained", d, 32'h0);
            wr16(8'h30, 16'h0020);
            @(negedge clk);
            chk("R11 irq cleared", {31'h0, irq}, 32'h0);
        end

        // R6 R7 R8 tuning blocks of every length
        for (int n = 1; n <= 16; n++) begin
            v = 16'((n * 16'h1D) & 16'h3F) | 16'h0040 | ((n & 1) != 0 ? 16'h4000 : 16'h8000);
            e = (v & ~16'h0040) | 16'h0080;
            wr16(8'h04, 16'(n));
            wr16(8'h3E, v);
            recv(n, n + 50);
            rd32(8'h3C, d); chk("R7 before update", {16'h0, d[31:16]}, {16'h0, v});
            rd32(8'h24, d); chk("R8 busy before", d, 32'h0206);
            @(negedge clk);
            rd32(8'h3C, d); chk("R7 tuning update", {16'h0, d[31:16]}, {16'h0, e});
            rd32(8'h24, d); chk("R8 released", d, 32'h0);
            rd32(8'h30, d); chk("R6 no ready", d, 32'h0);
            @(negedge clk);
            chk("R6 no irq", {31'h0, irq}, 32'h0);
        end

        // R6 buffer untouched by tuning block
        wr16(8'h3E, 16'h0000);
        wr16(8'h04, 16'd8);
        recv(8, 7);
        @(negedge clk);
        drain(7, 0, 4, "R4 first half");
        wr16(8'h3E, 16'h0040);
        recv(8, 99);
        @(negedge clk);
        rd32(8'h24, d); chk("R8 avail kept", d, 32'h0800);
        drain(7, 4, 4, "R6 buffer kept");
        rd32(8'h24, d); chk("R13 drained", d, 32'h0);
        wr16(8'h30, 16'h0020);
        wr16(8'h3E, 16'h0000);

        // R9 zero count multi-block request ignored
        wr16(8'h0C, 16'h0022);
        wr16(8'h06, 16'h0000);
        wr16(8'h04, 16'd4);
        recv(4, 3);
        @(negedge clk);
        rd32(8'h24, d); chk("R9 ignored pres", d, 32'h0);
        rd32(8'h30, d); chk("R9 ignored sts", d, 32'h0);

        // R12 count decrement
        wr16(8'h06, 16'd3);
        wr16(8'h04, 16'd2);
        recv(2, 11);
        rd32(8'h04, d); chk("R12 decremented", d, {16'd2, 16'd2});
        @(negedge clk);
        drain(11, 0, 2, "R4 after count");
        wr16(8'h0C, 16'h0002);
        wr16(8'h06, 16'h0000);
        recv(2, 12);
        rd32(8'h04, d); chk("R12 no wrap", d, {16'd0, 16'd2});
        @(negedge clk);
        rd32(8'h24, d); chk("R9 single not blocked", d, 32'h0A06);
        drain(12, 0, 2, "R4 single");
        wr16(8'h0C, 16'h0000);
        wr16(8'h30, 16'h0020);

        // R14 zero size ignored
        wr16(8'h04, 16'h1000);
        @(negedge clk);
        blk_req = 1'b1;
        @(negedge clk);
        blk_req = 1'b0;
        rd32(8'h24, d); chk("R14 zero size", d, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule